// File: doc/BRIEF.md
# Four-Phase Multiplexed Bus Sequencer

This block runs single read and write accesses on a 16-bit bus that carries the address and then the data on the same wires. Time on the bus is divided into machine cycles of four phases. One clock period of `clk` is one phase, and the phases P1, P2, P3 and P4 follow each other without a gap from reset. Each control edge the block produces is tied to one particular phase. The block drives an address strobe (`sync_o`), a read-data strobe (`din_o`) and a write-data strobe (`dout_o`), and it controls the output enable of the bus drivers. The addressed device holds an access open by keeping `reply_i` low. Each phase-3 sample of `reply_i` that is low makes the block repeat the data cycle.

The core hands over a request on a valid/ready channel. That request holds the direction, the address and the write data. The request must stay stable while `req_valid` is high, until a cycle in which `req_ready` is also high. `req_ready` rises only in P4 of an idle machine cycle. This is the back-pressure: an access that is in progress, or a BUSY request from an external DMA master, keeps the core waiting. `rsp_valid` is a plain one-clock pulse that marks the end of every access, and it has no back-pressure. On a read, `rsp_rdata` holds the captured word from that pulse until the next read completes. While `busy_i` is high, the sequencer starts no access and keeps its bus drivers off, so that the other master can use the bus.

Top module: `fourph_bus_seq`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it, `sync_o`, `din_o`, `dout_o`, `bus_oe`, `req_ready` and `rsp_valid` are low. The first clock after reset is P1, and the phases then repeat P1, P2, P3, P4.
- R2: A request is taken in P4 of an idle cycle. In the next cycle (the address cycle), `bus_oe` is high and `bus_out` holds the address for all four phases. `sync_o` rises at P2 of that cycle.
- R3: For a read, `bus_oe` drops at P1 of the cycle after the address cycle, and `din_o` rises at P2 of that cycle. `din_o` then stays high through every repeated data cycle.
- R4: For a write, `dout_o` rises at P1 of the cycle after the address cycle, together with `bus_oe` and the write data on `bus_out`.
- R5: A low `reply_i` at P3 of a data cycle repeats that whole data cycle. A high `reply_i` at P3 completes the access. An access with n repeats keeps `sync_o` high for 3 + 4(n+1) + 1 clocks.
- R6: A read ends with `sync_o` and `din_o` both falling at P2 of the cycle after the completing one, so `din_o` is high for 3 + 4n + 1 clocks. A write ends with `sync_o` falling at P2 and `dout_o` falling at P4 of that cycle, so `dout_o` is high for 4(n+1) + 3 clocks. `bus_oe` drops at the next P1.
- R7: `req_ready` is high only in P4 of an idle cycle with `busy_i` low. While `busy_i` is high, no access starts.
- R8: `rsp_valid` is high for exactly one clock, in P4 of the completing cycle. For a read, `rsp_rdata` equals `bus_in` as sampled at that cycle's P3.
- R9: `bus_oe` is low in idle cycles and during the read data cycles, and never high together with `din_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one period per phase |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request taken in this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| bus_out | output | 16 | Value driven onto the shared bus |
| bus_oe | output | 1 | Output enable for the bus drivers |
| bus_in | input | 16 | Value read from the shared bus |
| sync_o | output | 1 | Address strobe, spans the access |
| din_o | output | 1 | Read-data strobe |
| dout_o | output | 1 | Write-data strobe |
| reply_i | input | 1 | Device reply, sampled at P3 |
| busy_i | input | 1 | External master holds the bus |

## Verification
Two events can fall in the same clock and need care. The first is a DMA `busy_i` request in the P4 slot where a pending core request would otherwise be taken. The second is a `reply_i` that arrives exactly at the P3 of the first data cycle, so that the access is done with no repeats. The bench raises `busy_i` at the acceptance slot with `req_valid` already high, then drops it one phase later, and checks that the access starts only at the next idle P4. It also runs accesses whose reply comes on the first P3 and on later P3s, and counts the strobe lengths to check the boundary between completing and repeating.

// File: rtl/fpbs_pkg.sv
package fpbs_pkg;
  localparam int NPH  = 4;
  localparam int PH_W = $clog2(NPH);
  typedef logic [PH_W-1:0] ph_t;
  localparam ph_t PH1 = ph_t'(0);
  localparam ph_t PH2 = ph_t'(1);
  localparam ph_t PH3 = ph_t'(2);
  localparam ph_t PH4 = ph_t'(NPH - 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_RDAT,
    S_WDAT,
    S_REND,
    S_WEND
  } seq_st_e;
endpackage

// File: rtl/fpbs_phase_gen.sv
module fpbs_phase_gen
  import fpbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output ph_t  ph
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH1;
    else if (ph == PH4) ph <= PH1;
    else ph <= ph + ph_t'(1);
  end
endmodule

// File: rtl/fpbs_ctrl.sv
module fpbs_ctrl
  import fpbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ph_t     ph,
  input  logic    req_valid,
  input  logic    req_write,
  input  logic    reply_i,
  input  logic    busy_i,
  output logic    req_ready,
  output logic    accept,
  output logic    sel_addr,
  output logic    capture,
  output logic    done,
  output logic    sync_o,
  output logic    din_o,
  output logic    dout_o,
  output logic    bus_oe
);
  seq_st_e st;
  logic    is_wr;
  logic    rep;
  logic    ok;
  logic    in_data;
  logic    last_ph;

  assign in_data   = (st == S_RDAT) || (st == S_WDAT);
  assign last_ph   = (ph == PH4);
  assign req_ready = (st == S_IDLE) && last_ph && !busy_i;
  assign accept    = req_ready && req_valid;
  assign capture   = (st == S_RDAT) && (ph == PH3) && reply_i;
  assign sel_addr  = (st == S_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      is_wr <= 1'b0;
      rep   <= 1'b0;
      ok    <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= in_data && (ph == PH3) && reply_i;
      if (in_data && (ph == PH3)) ok <= reply_i;
      unique case (st)
        S_IDLE: begin
          if (accept) begin
            st    <= S_ADDR;
            is_wr <= req_write;
            rep   <= 1'b0;
            ok    <= 1'b0;
          end
        end
        S_ADDR: if (last_ph) st <= is_wr ? S_WDAT : S_RDAT;
        S_RDAT: begin
          if (last_ph) begin
            if (ok) st <= S_REND;
            else rep <= 1'b1;
          end
        end
        S_WDAT: begin
          if (last_ph) begin
            if (ok) st <= S_WEND;
            else rep <= 1'b1;
          end
        end
        S_REND, S_WEND: if (last_ph) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    sync_o = 1'b0;
    din_o  = 1'b0;
    dout_o = 1'b0;
    bus_oe = 1'b0;
    unique case (st)
      S_ADDR: begin
        bus_oe = 1'b1;
        sync_o = (ph != PH1);
      end
      S_RDAT: begin
        sync_o = 1'b1;
        din_o  = rep || (ph != PH1);
      end
      S_WDAT: begin
        sync_o = 1'b1;
        dout_o = 1'b1;
        bus_oe = 1'b1;
      end
      S_REND: begin
        sync_o = (ph == PH1);
        din_o  = (ph == PH1);
      end
      S_WEND: begin
        sync_o = (ph == PH1);
        dout_o = (ph != PH4);
        bus_oe = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpbs_datapath.sv
module fpbs_datapath #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             sel_addr,
  input  logic             bus_oe,
  input  logic             capture,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic [BUS_W-1:0] rdata
);
  logic [BUS_W-1:0] addr_q;
  logic [BUS_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata <= bus_in;
    end
  end

  always_comb begin
    if (!bus_oe) bus_out = '0;
    else if (sel_addr) bus_out = addr_q;
    else bus_out = wdata_q;
  end
endmodule

// File: rtl/fourph_bus_seq.sv
module fourph_bus_seq
  import fpbs_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_rdata,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  input  logic [BUS_W-1:0] bus_in,
  output logic             sync_o,
  output logic             din_o,
  output logic             dout_o,
  input  logic             reply_i,
  input  logic             busy_i
);
  ph_t  ph_q;
  logic accept;
  logic sel_addr;
  logic capture;

  fpbs_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .ph    (ph_q)
  );

  fpbs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph_q),
    .req_valid (req_valid),
    .req_write (req_write),
    .reply_i   (reply_i),
    .busy_i    (busy_i),
    .req_ready (req_ready),
    .accept    (accept),
    .sel_addr  (sel_addr),
    .capture   (capture),
    .done      (rsp_valid),
    .sync_o    (sync_o),
    .din_o     (din_o),
    .dout_o    (dout_o),
    .bus_oe    (bus_oe)
  );

  fpbs_datapath #(.BUS_W(BUS_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .sel_addr  (sel_addr),
    .bus_oe    (bus_oe),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .rdata     (rsp_rdata)
  );
endmodule

// File: rtl/fourph_bus_seq_chk.sv
module fourph_bus_seq_chk
  import fpbs_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input ph_t  ph,
  input logic sync_o,
  input logic din_o,
  input logic dout_o,
  input logic bus_oe,
  input logic req_valid,
  input logic req_ready,
  input logic busy_i,
  input logic rsp_valid
);
  // R2
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> (ph == PH2) && bus_oe);
  // R6
  sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_o) |-> (ph == PH2));
  // R3
  din_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(din_o) |-> (ph == PH2) && $past(sync_o));
  // R4
  dout_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_o) |-> (ph == PH1) && bus_oe && sync_o);
  // R6
  dout_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_o) |-> (ph == PH4));
  // R9
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din_o |-> !bus_oe);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && req_valid) |-> !req_ready);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8
  done_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ph == PH4));
endmodule

bind fourph_bus_seq fourph_bus_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ph        (ph_q),
  .sync_o    (sync_o),
  .din_o     (din_o),
  .dout_o    (dout_o),
  .bus_oe    (bus_oe),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy_i    (busy_i),
  .rsp_valid (rsp_valid)
);

// File: tb/fourph_bus_seq_tb_top.sv
`timescale 1ns/1ps
module fourph_bus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic [15:0] bus_in = '0;
  logic        sync_o, din_o, dout_o;
  logic        reply_i = 1'b0;
  logic        busy_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int wait_n = 0;
  int sync_cnt = 0;
  int sync_run = 0;
  int din_run = 0;
  int dout_run = 0;
  logic [15:0] mem [16];

  always #2 clk = ~clk;

  fourph_bus_seq dut_i (.*);

  // reference model state, advanced on every rising edge
  int m_ph, m_st, m_done, m_rep, m_ok, m_w;
  logic [15:0] m_addr, m_wd, m_rd;
  initial begin
    m_ph = 0; m_st = 0; m_done = 0; m_rep = 0; m_ok = 0; m_w = 0;
    m_addr = 0; m_wd = 0; m_rd = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_st = 0; m_done = 0; m_rep = 0; m_ok = 0; m_rd = 0;
    end else begin
      m_done = 0;
      if ((m_st == 2 || m_st == 3) && m_ph == 2) begin
        m_ok = reply_i;
        if (reply_i) begin
          m_done = 1;
          if (m_st == 2) m_rd = bus_in;
        end
      end
      if (m_ph == 3) begin
        case (m_st)
          0: if (req_valid && !busy_i) begin
               m_st = 1; m_w = req_write; m_addr = req_addr; m_wd = req_wdata;
               m_rep = 0; m_ok = 0;
             end
          1: m_st = m_w ? 3 : 2;
          2: if (m_ok) m_st = 4; else m_rep = 1;
          3: if (m_ok) m_st = 5; else m_rep = 1;
          default: m_st = 0;
        endcase
      end
      m_ph = (m_ph + 1) % 4;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    bit e_sync, e_din, e_dout, e_oe, e_rdy;
    cyc++;
    if (rst_n) begin
      e_sync = (m_st == 1 && m_ph != 0) || m_st == 2 || m_st == 3 || ((m_st == 4 || m_st == 5) && m_ph == 0);
      e_din  = (m_st == 2 && (m_rep == 1 || m_ph != 0)) || (m_st == 4 && m_ph == 0);
      e_dout = m_st == 3 || (m_st == 5 && m_ph != 3);
      e_oe   = m_st == 1 || m_st == 3 || m_st == 5;
      e_rdy  = m_st == 0 && m_ph == 3 && !busy_i;
      chk(sync_o == e_sync, "R2 sync_o", sync_o, e_sync);
      chk(din_o == e_din, "R3 din_o", din_o, e_din);
      chk(dout_o == e_dout, "R4 dout_o", dout_o, e_dout);
      chk(bus_oe == e_oe, "R9 bus_oe", bus_oe, e_oe);
      chk(req_ready == e_rdy, "R7 req_ready", req_ready, e_rdy);
      chk(rsp_valid == (m_done == 1), "R8 rsp_valid", rsp_valid, m_done);
      if (e_oe) chk(bus_out == (m_st == 1 ? m_addr : m_wd), "R2 bus_out", bus_out, m_st == 1 ? m_addr : m_wd);
      if (m_done == 1 && m_st == 2) chk(rsp_rdata == m_rd, "R8 rsp_rdata", rsp_rdata, m_rd);
    end
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d actual=hung expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // device side: reply after wait_n repeats, strobe lengths counted
  always @(posedge clk) begin
    #1;
    if (sync_o) sync_cnt++; else sync_cnt = 0;
    reply_i = sync_o && (sync_cnt >= 6 + 4 * wait_n);
    if (sync_o) sync_run++;
    if (din_o) din_run++;
    if (dout_o) dout_run++;
  end

  always_comb bus_in = mem[dut_i.bus_oe ? 4'h0 : req_addr[3:0]];

  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d, input int wt);
    @(posedge clk); #1;
    wait_n = wt; sync_run = 0; din_run = 0; dout_run = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
    if (wr) mem[a[3:0]] = d;
    do @(negedge clk); while (!rsp_valid);
    if (!wr) chk(rsp_rdata == mem[a[3:0]], "R8 read data", rsp_rdata, mem[a[3:0]]);
    do @(negedge clk); while (bus_oe || sync_o);
    chk(sync_run == 3 + 4 * (wt + 1) + 1, "R5 sync length", sync_run, 3 + 4 * (wt + 1) + 1);
    if (wr) chk(dout_run == 4 * (wt + 1) + 3, "R6 dout length", dout_run, 4 * (wt + 1) + 3);
    else    chk(din_run == 3 + 4 * wt + 1, "R6 din length", din_run, 3 + 4 * wt + 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(!sync_o && !din_o && !dout_o && !bus_oe && !rsp_valid && !req_ready, "R1 reset outputs",
        {sync_o, din_o, dout_o, bus_oe, rsp_valid, req_ready}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(!sync_o && !bus_oe && !req_ready, "R1 first phase idle", {sync_o, bus_oe, req_ready}, 0);
    access(1, 16'h1234, 16'hBEEF, 0);
    access(1, 16'h2A05, 16'h5A5A, 2);
    access(0, 16'h1234, 16'h0, 0);
    access(0, 16'h2A05, 16'h0, 3);
    // R7: BUSY held with a pending request blocks the start
    @(posedge clk); #1 busy_i = 1; req_valid = 1; req_write = 0; req_addr = 16'h0004;
    repeat (13) @(negedge clk);
    chk(!sync_o && !bus_oe, "R7 no access while busy", {sync_o, bus_oe}, 0);
    @(posedge clk); #1 req_valid = 0; busy_i = 0;
    // R7: busy rises exactly at the acceptance slot, released one phase later
    mem[5] = 16'hC3C3;
    fork
      access(0, 16'h0005, 16'h0, 1);
      begin
        do begin @(posedge clk); #1; end while (!(dut_i.req_ready === 1'b0 && m_ph == 3));
        busy_i = 1;
        @(posedge clk); #1 busy_i = 0;
      end
    join
    access(1, 16'h000F, 16'h0F0F, 1);
    access(0, 16'h000F, 16'h0, 0);
    repeat (8) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule